// File: doc/BRIEF.md
# Flash Page Access Guard

This block sits between a flash operation sequencer and the flash array and decides, one request at a time, whether the operation may proceed. Software sets up eight protection windows. Each window has an enable, a first page, a length in pages, and separate rights to read, program and erase. A three-bit fallback set of rights covers any page that no enabled window claims. Erasing a whole bank does not consult the windows. It is allowed only by a per-bank enable bit.

A permitted request is forwarded to the flash one cycle later, with its opcode, bank and page unchanged. A refused request is never forwarded. Instead the block pulses an error for one cycle and records the offending page and bank, which stay visible until the next refusal. The sequencer treats the refusal as a finished operation that failed, so it waits for no completion from the flash. Two one-way locks freeze the configuration: one for the windows and the fallback rights, one for the bank erase enables. Once a lock is cleared, only a reset opens it again.

Top module: `flash_page_guard`

## Requirements
- R1: After reset every right is denied: all windows are disabled, the fallback rights are 0, and both bank erase enables are 0. Both locks are open (1). `fwd_req_o` and `op_err_o` are 0, and `err_page_o` and `err_bank_o` are 0.
- R2: A window write word carries enable in bit 0, read right in bit 1, program right in bit 2, erase right in bit 3, first page in bits 12:4 and length in pages in bits 24:16. A window matches page p when it is enabled and first ≤ p < first + length, with the sum taken without wrap. A length of 0 matches nothing.
- R3: When several enabled windows match, the window with the lowest index alone supplies the rights.
- R4: A page matched by no enabled window uses the fallback rights: read in bit 0, program in bit 1, erase in bit 2.
- R5: Request opcodes are 0 read, 1 program, 2 page erase and 3 bank erase. Read uses the read right, program uses the program right, and page erase uses the erase right. Bank erase of bank b uses only bit b of the bank erase enable word and ignores the windows and the fallback rights.
- R6: A permitted request presented with `req_valid_i` in cycle n gives `fwd_req_o`=1 in cycle n+1, with `fwd_op_o`, `fwd_bank_o` and `fwd_page_o` equal to the request, and `op_err_o`=0.
- R7: A refused request in cycle n gives `op_err_o`=1 for cycle n+1 only, with `fwd_req_o`=0. `err_page_o` and `err_bank_o` take the request's page and bank and hold them until the next refusal.
- R8: Each lock output is cleared by a write of 0 and ignores writes of 1 once cleared.
- R9: While the window lock is 0, writes to windows and to the fallback rights are ignored. While the bank lock is 0, writes to the bank erase enables are ignored.
- R10: A request in the same cycle as a configuration write is judged against the configuration held before that write.
- R11: A configuration write in the same cycle as the write that clears its lock still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_we_i | input | 8 | One write strobe per window |
| win_wdata_i | input | 32 | Window write word |
| dflt_we_i | input | 1 | Fallback rights write strobe |
| dflt_wdata_i | input | 3 | Fallback rights: read, program, erase |
| bank_we_i | input | 1 | Bank erase enable write strobe |
| bank_wdata_i | input | 2 | Bank erase enable, one bit per bank |
| win_lock_we_i | input | 1 | Window lock write strobe |
| win_lock_wdata_i | input | 1 | Window lock write value |
| bank_lock_we_i | input | 1 | Bank lock write strobe |
| bank_lock_wdata_i | input | 1 | Bank lock write value |
| win_open_o | output | 1 | Window lock state, 1 = writable |
| bank_open_o | output | 1 | Bank lock state, 1 = writable |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Request opcode |
| req_bank_i | input | 1 | Request bank |
| req_page_i | input | 9 | Request page |
| fwd_req_o | output | 1 | Permitted request forwarded to flash |
| fwd_op_o | output | 2 | Forwarded opcode |
| fwd_bank_o | output | 1 | Forwarded bank |
| fwd_page_o | output | 9 | Forwarded page |
| op_err_o | output | 1 | Refusal pulse |
| err_page_o | output | 9 | Page of the last refusal |
| err_bank_o | output | 1 | Bank of the last refusal |

## Verification
Two pairs of functions can meet in one cycle. The first is a request and a change to the configuration that would alter its verdict. The bench presents a read in the same cycle that it writes the fallback rights from read-allowed to read-denied. It then expects the read to be forwarded, and the next identical read to be refused. The second is a lock clear and a guarded write. The bench writes a window in the same cycle that it clears the window lock. It then judges a page sweep with that window in force, and expects later window and fallback writes to leave the sweep results unchanged.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int unsigned PAGE_W  = 9;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PERM_W  = 3;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_BERASE = 2'd3
  } fpg_op_e;

  typedef struct packed {
    logic rd;
    logic prog;
    logic erase;
  } fpg_perm_t;

  typedef struct packed {
    logic              en;
    fpg_perm_t         perm;
    logic [PAGE_W-1:0] first;
    logic [PAGE_W-1:0] len;
  } fpg_win_t;
endpackage

// File: rtl/fpg_lock.sv
module fpg_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic open_o
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (we_i) open_d = open_q & wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b1;
    else         open_q <= open_d;
  end

  assign open_o = open_q;
endmodule

// File: rtl/fpg_cfg.sv
module fpg_cfg
  import fpg_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     win_open_i,
  input  logic                     bank_open_i,
  input  logic [NUM_WIN-1:0]       win_we_i,
  input  logic [WORD_W-1:0]        win_wdata_i,
  input  logic                     dflt_we_i,
  input  logic [PERM_W-1:0]        dflt_wdata_i,
  input  logic                     bank_we_i,
  input  logic [NUM_BANKS-1:0]     bank_wdata_i,
  output fpg_win_t [NUM_WIN-1:0]   win_o,
  output fpg_perm_t                dflt_o,
  output logic [NUM_BANKS-1:0]     bank_en_o
);
  fpg_win_t wword;
  logic     unused_wbits;

  // Field layout of the window write word
  always_comb begin
    wword.en         = win_wdata_i[0];
    wword.perm.rd    = win_wdata_i[1];
    wword.perm.prog  = win_wdata_i[2];
    wword.perm.erase = win_wdata_i[3];
    wword.first      = win_wdata_i[4 +: PAGE_W];
    wword.len        = win_wdata_i[16 +: PAGE_W];
  end
  assign unused_wbits = ^{win_wdata_i[WORD_W-1:16+PAGE_W], win_wdata_i[15:4+PAGE_W]};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    fpg_win_t q, d;
    logic     ce;
    assign ce = win_we_i[i] & win_open_i;
    always_comb d = ce ? wword : q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign win_o[i] = q;
  end

  fpg_perm_t dflt_q, dflt_d;
  logic [NUM_BANKS-1:0] bank_q, bank_d;

  always_comb begin
    dflt_d = dflt_q;
    if (dflt_we_i && win_open_i)
      dflt_d = '{rd: dflt_wdata_i[0], prog: dflt_wdata_i[1], erase: dflt_wdata_i[2]};
    bank_d = bank_q;
    if (bank_we_i && bank_open_i) bank_d = bank_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dflt_q <= '0;
      bank_q <= '0;
    end else begin
      dflt_q <= dflt_d;
      bank_q <= bank_d;
    end
  end

  assign dflt_o    = dflt_q;
  assign bank_en_o = bank_q;
endmodule

// File: rtl/fpg_decide.sv
module fpg_decide
  import fpg_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  fpg_win_t [NUM_WIN-1:0] win_i,
  input  fpg_perm_t              dflt_i,
  input  logic [NUM_BANKS-1:0]   bank_en_i,
  input  fpg_op_e                op_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [PAGE_W-1:0]      page_i,
  output logic                   allow_o
);
  logic [NUM_WIN-1:0] hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    logic [PAGE_W:0] lo, hi, pg;
    assign lo = {1'b0, win_i[i].first};
    assign hi = lo + {1'b0, win_i[i].len};
    assign pg = {1'b0, page_i};
    assign hit[i] = win_i[i].en && (pg >= lo) && (pg < hi);
  end

  fpg_perm_t perm;
  always_comb begin
    perm = dflt_i;
    // Walk from the highest index so the lowest matching window wins
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) perm = win_i[i].perm;
    end
  end

  always_comb begin
    unique case (op_i)
      OP_READ:   allow_o = perm.rd;
      OP_PROG:   allow_o = perm.prog;
      OP_PERASE: allow_o = perm.erase;
      default:   allow_o = bank_en_i[bank_i];
    endcase
  end
endmodule

// File: rtl/flash_page_guard.sv
module flash_page_guard
  import fpg_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WIN-1:0]   win_we_i,
  input  logic [WORD_W-1:0]    win_wdata_i,
  input  logic                 dflt_we_i,
  input  logic [PERM_W-1:0]    dflt_wdata_i,
  input  logic                 bank_we_i,
  input  logic [NUM_BANKS-1:0] bank_wdata_i,
  input  logic                 win_lock_we_i,
  input  logic                 win_lock_wdata_i,
  input  logic                 bank_lock_we_i,
  input  logic                 bank_lock_wdata_i,
  output logic                 win_open_o,
  output logic                 bank_open_o,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [PAGE_W-1:0]    req_page_i,
  output logic                 fwd_req_o,
  output logic [1:0]           fwd_op_o,
  output logic [BANK_W-1:0]    fwd_bank_o,
  output logic [PAGE_W-1:0]    fwd_page_o,
  output logic                 op_err_o,
  output logic [PAGE_W-1:0]    err_page_o,
  output logic [BANK_W-1:0]    err_bank_o
);
  fpg_win_t [NUM_WIN-1:0] win;
  fpg_perm_t              dflt;
  logic [NUM_BANKS-1:0]   bank_en;
  logic                   allow;

  fpg_lock u_win_lock (
    .clk_i, .rst_ni, .we_i(win_lock_we_i), .wdata_i(win_lock_wdata_i), .open_o(win_open_o)
  );
  fpg_lock u_bank_lock (
    .clk_i, .rst_ni, .we_i(bank_lock_we_i), .wdata_i(bank_lock_wdata_i), .open_o(bank_open_o)
  );

  fpg_cfg #(.NUM_WIN(NUM_WIN), .NUM_BANKS(NUM_BANKS)) u_cfg (
    .clk_i, .rst_ni,
    .win_open_i(win_open_o), .bank_open_i(bank_open_o),
    .win_we_i, .win_wdata_i, .dflt_we_i, .dflt_wdata_i, .bank_we_i, .bank_wdata_i,
    .win_o(win), .dflt_o(dflt), .bank_en_o(bank_en)
  );

  fpg_decide #(.NUM_WIN(NUM_WIN), .NUM_BANKS(NUM_BANKS)) u_decide (
    .win_i(win), .dflt_i(dflt), .bank_en_i(bank_en),
    .op_i(fpg_op_e'(req_op_i)), .bank_i(req_bank_i), .page_i(req_page_i),
    .allow_o(allow)
  );

  logic              fwd_q, fwd_d, err_q, err_d;
  logic [1:0]        op_q, op_d;
  logic [BANK_W-1:0] bank_q, bank_d, ebank_q, ebank_d;
  logic [PAGE_W-1:0] page_q, page_d, epage_q, epage_d;

  always_comb begin
    fwd_d   = req_valid_i & allow;
    err_d   = req_valid_i & ~allow;
    op_d    = op_q;
    bank_d  = bank_q;
    page_d  = page_q;
    ebank_d = ebank_q;
    epage_d = epage_q;
    if (fwd_d) begin
      op_d   = req_op_i;
      bank_d = req_bank_i;
      page_d = req_page_i;
    end
    if (err_d) begin
      ebank_d = req_bank_i;
      epage_d = req_page_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q   <= 1'b0;
      err_q   <= 1'b0;
      op_q    <= '0;
      bank_q  <= '0;
      page_q  <= '0;
      ebank_q <= '0;
      epage_q <= '0;
    end else begin
      fwd_q   <= fwd_d;
      err_q   <= err_d;
      op_q    <= op_d;
      bank_q  <= bank_d;
      page_q  <= page_d;
      ebank_q <= ebank_d;
      epage_q <= epage_d;
    end
  end

  assign fwd_req_o  = fwd_q;
  assign fwd_op_o   = op_q;
  assign fwd_bank_o = bank_q;
  assign fwd_page_o = page_q;
  assign op_err_o   = err_q;
  assign err_page_o = epage_q;
  assign err_bank_o = ebank_q;
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_op_i,
  input logic       req_bank_i,
  input logic [8:0] req_page_i,
  input logic       fwd_req_o,
  input logic [1:0] fwd_op_o,
  input logic       fwd_bank_o,
  input logic [8:0] fwd_page_o,
  input logic       op_err_o,
  input logic [8:0] err_page_o,
  input logic       err_bank_o,
  input logic       win_open_o,
  input logic       bank_open_o
);
  assert_one_verdict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (fwd_req_o ^ op_err_o));

  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_o || op_err_o) |-> $past(req_valid_i));

  assert_fwd_payload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_req_o |-> (fwd_page_o == $past(req_page_i) && fwd_bank_o == $past(req_bank_i)
                   && fwd_op_o == $past(req_op_i)));

  assert_err_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_err_o |-> (err_page_o == $past(req_page_i) && err_bank_o == $past(req_bank_i)));

  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_err_o |-> ($stable(err_page_o) && $stable(err_bank_o)));

  assert_win_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open_o |=> !win_open_o);

  assert_bank_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_open_o |=> !bank_open_o);
endmodule

bind flash_page_guard fpg_checker u_fpg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_bank_i(req_bank_i), .req_page_i(req_page_i),
  .fwd_req_o(fwd_req_o), .fwd_op_o(fwd_op_o), .fwd_bank_o(fwd_bank_o), .fwd_page_o(fwd_page_o),
  .op_err_o(op_err_o), .err_page_o(err_page_o), .err_bank_o(err_bank_o),
  .win_open_o(win_open_o), .bank_open_o(bank_open_o)
);

// File: tb/flash_page_guard_bench.sv
module flash_page_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  win_we = '0;
  logic [31:0] win_wdata = '0;
  logic        dflt_we = 1'b0;
  logic [2:0]  dflt_wdata = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_wdata = '0;
  logic        wl_we = 1'b0, wl_wd = 1'b0, bl_we = 1'b0, bl_wd = 1'b0;
  logic        win_open, bank_open;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic        req_bank = 1'b0;
  logic [8:0]  req_page = '0;
  logic        fwd_req, fwd_bank, op_err, err_bank;
  logic [1:0]  fwd_op;
  logic [8:0]  fwd_page, err_page;

  flash_page_guard u_flash_page_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .win_we_i(win_we), .win_wdata_i(win_wdata),
    .dflt_we_i(dflt_we), .dflt_wdata_i(dflt_wdata),
    .bank_we_i(bank_we), .bank_wdata_i(bank_wdata),
    .win_lock_we_i(wl_we), .win_lock_wdata_i(wl_wd),
    .bank_lock_we_i(bl_we), .bank_lock_wdata_i(bl_wd),
    .win_open_o(win_open), .bank_open_o(bank_open),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_bank_i(req_bank), .req_page_i(req_page),
    .fwd_req_o(fwd_req), .fwd_op_o(fwd_op), .fwd_bank_o(fwd_bank), .fwd_page_o(fwd_page),
    .op_err_o(op_err), .err_page_o(err_page), .err_bank_o(err_bank)
  );

  int checks = 0;
  int errors = 0;

  // Bench model of the configuration, kept from the writes it issues
  logic [31:0] m_win [8];
  logic [2:0]  m_dflt = '0;
  logic [1:0]  m_bank = '0;
  logic        m_wopen = 1'b1, m_bopen = 1'b1;
  logic [8:0]  m_epage = '0;
  logic        m_ebank = 1'b0;

  initial for (int i = 0; i < 8; i++) m_win[i] = '0;

  function automatic logic exp_allow(input logic [1:0] op, input logic bk, input logic [8:0] pg);
    logic [2:0] perm;  // {erase, prog, rd}
    int lo, len;
    if (op == 2'd3) return m_bank[bk];
    perm = m_dflt;
    for (int i = 7; i >= 0; i--) begin
      lo  = int'(m_win[i][12:4]);
      len = int'(m_win[i][24:16]);
      if (m_win[i][0] && int'(pg) >= lo && int'(pg) < lo + len) perm = m_win[i][3:1] >> 0 == 3'b0 ? 3'b0 :
          {m_win[i][3], m_win[i][2], m_win[i][1]};
    end
    case (op)
      2'd0: return perm[0];
      2'd1: return perm[1];
      default: return perm[2];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Judge outputs one cycle after a request of (op, bk, pg) with verdict a
  task automatic judge(input string req, input logic [1:0] op, input logic bk,
                       input logic [8:0] pg, input logic a);
    if (a) begin
      check(fwd_req && !op_err && fwd_op == op && fwd_bank == bk && fwd_page == pg, req,
            $sformatf("op%0d bank%0d page%0d fwd=%0b err=%0b out=%0d/%0d/%0d expected forward",
                      op, bk, pg, fwd_req, op_err, fwd_op, fwd_bank, fwd_page));
    end else begin
      m_epage = pg;
      m_ebank = bk;
      check(!fwd_req && op_err, req,
            $sformatf("op%0d bank%0d page%0d fwd=%0b err=%0b expected refusal", op, bk, pg, fwd_req, op_err));
    end
    check(err_page == m_epage && err_bank == m_ebank, "R7",
          $sformatf("err page/bank %0d/%0d expected %0d/%0d", err_page, err_bank, m_epage, m_ebank));
  endtask

  task automatic sweep(input string req);
    for (int op = 0; op < 4; op++)
      for (int bk = 0; bk < 2; bk++)
        for (int pg = 0; pg < 512; pg++) begin
          logic a;
          a = exp_allow(2'(op), 1'(bk), 9'(pg));
          req_valid = 1'b1; req_op = 2'(op); req_bank = 1'(bk); req_page = 9'(pg);
          @(negedge clk);
          judge(req, 2'(op), 1'(bk), 9'(pg), a);
        end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] wword(input bit en, input logic [2:0] epr, input int first, input int len);
    return {7'd0, 9'(len), 3'd0, 9'(first), epr, en};  // epr = {erase, prog, rd}
  endfunction

  task automatic wr_win(input int i, input logic [31:0] w);
    win_we = 8'(1 << i); win_wdata = w;
    if (m_wopen) m_win[i] = w;
    @(negedge clk);
    win_we = '0;
  endtask

  task automatic wr_dflt(input logic [2:0] v);
    dflt_we = 1'b1; dflt_wdata = v;
    if (m_wopen) m_dflt = v;
    @(negedge clk);
    dflt_we = 1'b0;
  endtask

  task automatic wr_bank(input logic [1:0] v);
    bank_we = 1'b1; bank_wdata = v;
    if (m_bopen) m_bank = v;
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!fwd_req && !op_err && err_page == 0 && err_bank == 0, "R1",
          $sformatf("fwd=%0b err=%0b epage=%0d expected 0/0/0", fwd_req, op_err, err_page));
    check(win_open && bank_open, "R1",
          $sformatf("locks %0b/%0b expected 1/1", win_open, bank_open));
    sweep("R1");

    // R2, R3, R4, R5: overlapping windows, empty window, disabled window, top-end window
    wr_win(0, wword(1, 3'b001, 10, 5));
    wr_win(1, wword(1, 3'b111, 12, 20));
    wr_win(2, wword(1, 3'b111, 40, 0));
    wr_win(3, wword(0, 3'b111, 50, 10));
    wr_win(7, wword(1, 3'b101, 500, 12));
    wr_dflt(3'b010);
    wr_bank(2'b10);
    sweep("R3");

    wr_win(4, wword(1, 3'b100, 0, 1));
    wr_dflt(3'b101);
    wr_bank(2'b01);
    sweep("R4");

    // R10: request alongside a write that would deny it
    req_valid = 1'b1; req_op = 2'd0; req_bank = 1'b0; req_page = 9'd300;
    dflt_we = 1'b1; dflt_wdata = 3'b000;
    @(negedge clk);
    dflt_we = 1'b0;
    judge("R10", 2'd0, 1'b0, 9'd300, 1'b1);
    m_dflt = 3'b000;
    @(negedge clk);
    judge("R10", 2'd0, 1'b0, 9'd300, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);

    // R11: window write together with clearing its lock
    win_we = 8'h20; win_wdata = wword(1, 3'b011, 200, 30); m_win[5] = win_wdata;
    wl_we = 1'b1; wl_wd = 1'b0;
    @(negedge clk);
    win_we = '0; wl_we = 1'b0; m_wopen = 1'b0;
    check(!win_open, "R8", $sformatf("window lock %0b expected 0", win_open));
    wl_we = 1'b1; wl_wd = 1'b1;
    @(negedge clk);
    wl_we = 1'b0;
    check(!win_open, "R8", $sformatf("window lock reopened %0b expected 0", win_open));
    // R9: guarded writes ignored
    wr_win(0, wword(1, 3'b111, 0, 511));
    wr_win(5, wword(0, 3'b000, 0, 0));
    wr_dflt(3'b111);
    bl_we = 1'b1; bl_wd = 1'b0;
    @(negedge clk);
    bl_we = 1'b0; m_bopen = 1'b0;
    check(!bank_open, "R8", $sformatf("bank lock %0b expected 0", bank_open));
    wr_bank(2'b11);
    sweep("R9");
    sweep("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule